// File: doc/BRIEF.md
# Two-Phase Interpolating FIR Engine

This block doubles the sample rate of a stream of signed samples. It runs entirely on one fast clock. A one-cycle input strobe marks each arriving sample, and the block generates its own output strobe at twice the input rate. Each accepted sample is written into a small circular sample store. A single multiply-accumulate unit then works through two polyphase branches, one after the other. The even branch pairs the even-indexed coefficients with the newest sample and every second older one. The odd branch pairs the odd-indexed coefficients with the samples in between.

Each branch result is rounded and saturated, then parked in a per-branch holding register. A retiming register releases the held results at fixed offsets from the accepting strobe. This makes output timing independent of how long the arithmetic took. The fixed offsets are half of the input period and the full input period. The coefficients, the widths, the store depth and the clock ratio are all parameters, and elaboration rejects combinations that cannot meet the timing.

Top module: `interp2_fir`

## Requirements
- R1: While reset is asserted and immediately after it, `out_valid` is 0 and `out_data` is 0. Every slot of the sample store reads as zero, so the first outputs see an all-zero history.
- R2: For newest sample x[n], the even-branch result is the sum over k of COEFS[2k]·x[n-2k], for k = 0 to TAPS/2-1.
- R3: For newest sample x[n], the odd-branch result is the sum over k of COEFS[2k+1]·x[n-1-2k], for k = 0 to TAPS/2-1.
- R4: The write position advances by exactly one, modulo DEPTH, after both branches finish. Results stay correct after the store has wrapped several times.
- R5: With ROUND=1, each sum is rounded by adding 2^(SHIFT-1) and then shifting right arithmetically by SHIFT. A sum of exactly +0.5 LSB rounds up, and a sum of -0.5 LSB rounds to 0.
- R6: The rounded value is saturated to the signed OUT_W range, from -2^(OUT_W-1) to 2^(OUT_W-1)-1.
- R7: Let E0 be the clock edge that accepts a strobe. The even result appears with `out_valid`=1 and `out_phase`=0 for the single cycle after edge E0+RATIO/2. The odd result appears with `out_phase`=1 for the single cycle after edge E0+RATIO. This gives exactly two pulses per accepted sample, even branch first. This timing also holds when strobes arrive back to back every RATIO cycles.
- R8: `out_data` does not change in any cycle in which `out_valid` is 0.
- R9: A strobe that arrives at an edge 1 to RATIO-1 cycles after an accepting edge is ignored. The sample is not stored and the output timing is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock, shared by input, output and arithmetic |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_stb | input | 1 | One-cycle strobe marking a new input sample |
| in_data | input | SAMPLE_W | Signed input sample, taken when `in_stb` is accepted |
| out_valid | output | 1 | One-cycle pulse marking a new output sample |
| out_phase | output | 1 | Branch of the current output: 0 even, 1 odd |
| out_data | output | OUT_W | Signed, rounded and saturated output sample |

## Verification
Each accepted strobe places two expected entries in a scoreboard. Each entry holds the exact clock count at which its pulse must appear, E0+RATIO/2 for the even branch and E0+RATIO for the odd one, together with the expected value and branch. A negative-edge collector compares every observed pulse against the next entry on count, branch and value. It also checks that `out_data` holds still between pulses. Because the expected counts come from the accepting edge, back-to-back strobes, idle gaps and ignored early strobes are all timed by the same rule. At the end, any pulse that never arrived is reported as missing.

// File: rtl/interp2_pkg.sv
package interp2_pkg;
   typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
   typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_e;
endpackage

// File: rtl/interp2_sample_ram.sv
module interp2_sample_ram #(
   parameter int SAMPLE_W = 16,
   parameter int DEPTH    = 8,
   localparam int AW      = $clog2(DEPTH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [AW-1:0]              waddr,
   input  logic signed [SAMPLE_W-1:0] wdata,
   input  logic [AW-1:0]              raddr,
   output logic signed [SAMPLE_W-1:0] rdata
);
   logic signed [SAMPLE_W-1:0] mem_q [DEPTH];

   // every slot starts at zero so early results see a silent history
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/interp2_seq.sv
module interp2_seq
   import interp2_pkg::*;
#(
   parameter int TAPS  = 8,
   parameter int DEPTH = 8,
   parameter int RATIO = 12,
   localparam int HALF   = TAPS / 2,
   localparam int KW     = $clog2(HALF),
   localparam int CIW    = KW + 1,
   localparam int AW     = $clog2(DEPTH),
   localparam int TW     = $clog2(RATIO + 1),
   localparam int HALF_P = RATIO / 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_stb,
   output logic           accept,
   output logic [AW-1:0]  wp,
   output logic [AW-1:0]  raddr,
   output logic [CIW-1:0] cidx,
   output logic           mac_en,
   output logic           mac_last,
   output logic           phase,
   output logic           show0,
   output logic           show1
);
   seq_state_e     state_q;
   phase_e         phase_q;
   logic [KW-1:0]  k_q;
   logic [AW-1:0]  wp_q;
   logic [TW-1:0]  tmr_q;

   // a strobe is taken only outside the window of the previous sample
   assign accept   = in_stb && (tmr_q == '0 || tmr_q == TW'(RATIO));
   assign mac_en   = (state_q == SEQ_RUN);
   assign mac_last = mac_en && (k_q == KW'(HALF - 1));
   assign cidx     = {k_q, phase_q};
   assign raddr    = wp_q - AW'(cidx);
   assign wp       = wp_q;
   assign phase    = phase_q;
   assign show0    = (tmr_q == TW'(HALF_P));
   assign show1    = (tmr_q == TW'(RATIO));

   // output slot timer, counts edges since the accepting edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q <= '0;
      end else if (accept) begin
         tmr_q <= TW'(1);
      end else if (show1) begin
         tmr_q <= '0;
      end else if (tmr_q != '0) begin
         tmr_q <= tmr_q + TW'(1);
      end
   end

   // branch sequencing through the shared multiplier
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         phase_q <= PH_EVEN;
         k_q     <= '0;
         wp_q    <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (accept) begin
                  state_q <= SEQ_RUN;
                  phase_q <= PH_EVEN;
                  k_q     <= '0;
               end
            end
            SEQ_RUN: begin
               if (mac_last) begin
                  k_q <= '0;
                  if (phase_q == PH_EVEN) begin
                     phase_q <= PH_ODD;
                  end else begin
                     state_q <= SEQ_IDLE;
                     phase_q <= PH_EVEN;
                     wp_q    <= wp_q + AW'(1);
                  end
               end else begin
                  k_q <= k_q + KW'(1);
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   // R9: an early strobe leaves the slot timer running undisturbed
   p_early_stb_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_stb && tmr_q != '0 && tmr_q != TW'(RATIO)) |=> (tmr_q == $past(tmr_q) + TW'(1)));

   // R4: the write position only ever steps by one
   p_wp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_q != $past(wp_q)) |-> (wp_q == $past(wp_q) + AW'(1)));

   // R7: even branch finished before its release slot
   p_even_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      show0 |-> (state_q == SEQ_IDLE || phase_q == PH_ODD));

   // R7: both branches finished before the odd release slot
   p_odd_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      show1 |-> (state_q == SEQ_IDLE));
endmodule

// File: rtl/interp2_mac.sv
module interp2_mac #(
   parameter int SAMPLE_W = 16,
   parameter int COEF_W   = 16,
   parameter int OUT_W    = 16,
   parameter int TAPS     = 8,
   parameter int SHIFT    = 15,
   parameter int ROUND    = 1,
   parameter logic signed [COEF_W-1:0] COEFS [TAPS] =
      '{-16'sd800, 16'sd0, 16'sd4800, 16'sd16384, 16'sd25000, 16'sd16384, 16'sd4800, -16'sd800},
   localparam int HALF  = TAPS / 2,
   localparam int CIW   = $clog2(HALF) + 1,
   localparam int PW    = SAMPLE_W + COEF_W,
   localparam int ACC_W = PW + $clog2(HALF) + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en,
   input  logic                       last,
   input  logic [CIW-1:0]             cidx,
   input  logic signed [SAMPLE_W-1:0] smp,
   output logic signed [OUT_W-1:0]    result
);
   localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);
   localparam logic signed [ACC_W-1:0] RND  = (SHIFT > 0) ? ACC_W'(64'sd1 <<< (SHIFT - 1)) : '0;

   logic signed [COEF_W-1:0] coef;
   logic signed [PW-1:0]     prod;
   logic signed [ACC_W-1:0]  acc_q;
   logic signed [ACC_W-1:0]  sum;
   logic signed [ACC_W-1:0]  adj;
   logic signed [ACC_W-1:0]  shifted;

   assign coef = COEFS[cidx];
   assign prod = smp * coef;
   assign sum  = acc_q + prod;

   generate
      if (ROUND != 0) begin : g_round
         assign adj = sum + RND;
      end else begin : g_trunc
         assign adj = sum;
      end
   endgenerate

   assign shifted = adj >>> SHIFT;

   always_comb begin
      if (shifted > MAXV)      result = MAXV[OUT_W-1:0];
      else if (shifted < MINV) result = MINV[OUT_W-1:0];
      else                     result = shifted[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (en)  acc_q <= last ? '0 : sum;
   end
endmodule

// File: rtl/interp2_retime.sv
module interp2_retime #(
   parameter int OUT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic                    load_phase,
   input  logic signed [OUT_W-1:0] load_data,
   input  logic                    show0,
   input  logic                    show1,
   output logic                    out_valid,
   output logic                    out_phase,
   output logic signed [OUT_W-1:0] out_data
);
   logic signed [OUT_W-1:0] hold_q [2];

   // first stage: one holding register per branch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q[0] <= '0;
         hold_q[1] <= '0;
      end else if (load) begin
         hold_q[load_phase] <= load_data;
      end
   end

   // second stage: release on the fixed output slots
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_phase <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= show0 || show1;
         if (show0) begin
            out_phase <= 1'b0;
            out_data  <= hold_q[0];
         end else if (show1) begin
            out_phase <= 1'b1;
            out_data  <= hold_q[1];
         end
      end
   end

   // R7: each release is a single-cycle pulse
   p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R8: data holds still between pulses
   p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));
endmodule

// File: rtl/interp2_fir.sv
module interp2_fir #(
   parameter int SAMPLE_W = 16,
   parameter int COEF_W   = 16,
   parameter int OUT_W    = 16,
   parameter int TAPS     = 8,
   parameter int DEPTH    = 8,
   parameter int RATIO    = 12,
   parameter int SHIFT    = 15,
   parameter int ROUND    = 1,
   parameter logic signed [COEF_W-1:0] COEFS [TAPS] =
      '{-16'sd800, 16'sd0, 16'sd4800, 16'sd16384, 16'sd25000, 16'sd16384, 16'sd4800, -16'sd800}
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_stb,
   input  logic signed [SAMPLE_W-1:0] in_data,
   output logic                       out_valid,
   output logic                       out_phase,
   output logic signed [OUT_W-1:0]    out_data
);
   localparam int HALF = TAPS / 2;
   localparam int CIW  = $clog2(HALF) + 1;
   localparam int AW   = $clog2(DEPTH);

   // elaboration checks on the parameter set
   generate
      if (TAPS < 4 || (TAPS % 2) != 0) begin : g_bad_taps
         $error("tap count must be even and at least 4");
      end
      if (DEPTH < TAPS || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("store depth must be a power of two covering the taps");
      end
      if (RATIO < TAPS + 2 || (RATIO % 2) != 0) begin : g_bad_ratio
         $error("clock ratio must be even and leave room for both branches");
      end
      if (ROUND != 0 && SHIFT < 1) begin : g_bad_shift
         $error("rounding needs a shift of at least one");
      end
   endgenerate

   logic                       accept;
   logic [AW-1:0]              wp;
   logic [AW-1:0]              raddr;
   logic [CIW-1:0]             cidx;
   logic                       mac_en;
   logic                       mac_last;
   logic                       phase;
   logic                       show0;
   logic                       show1;
   logic signed [SAMPLE_W-1:0] rdata;
   logic signed [OUT_W-1:0]    result;

   interp2_seq #(.TAPS(TAPS), .DEPTH(DEPTH), .RATIO(RATIO)) i_seq (
      .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .accept(accept),
      .wp(wp), .raddr(raddr), .cidx(cidx), .mac_en(mac_en),
      .mac_last(mac_last), .phase(phase), .show0(show0), .show1(show1)
   );

   interp2_sample_ram #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) i_ram (
      .clk(clk), .rst_n(rst_n), .we(accept), .waddr(wp), .wdata(in_data),
      .raddr(raddr), .rdata(rdata)
   );

   interp2_mac #(
      .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .TAPS(TAPS),
      .SHIFT(SHIFT), .ROUND(ROUND), .COEFS(COEFS)
   ) i_mac (
      .clk(clk), .rst_n(rst_n), .en(mac_en), .last(mac_last),
      .cidx(cidx), .smp(rdata), .result(result)
   );

   interp2_retime #(.OUT_W(OUT_W)) i_retime (
      .clk(clk), .rst_n(rst_n), .load(mac_last), .load_phase(phase),
      .load_data(result), .show0(show0), .show1(show1),
      .out_valid(out_valid), .out_phase(out_phase), .out_data(out_data)
   );
endmodule

// File: tb/test_interp2_fir.sv
`timescale 1ns/1ps
module test_interp2_fir;
   localparam int SAMPLE_W = 16;
   localparam int OUT_W    = 16;
   localparam int TAPS     = 8;
   localparam int DEPTH    = 8;
   localparam int RATIO    = 12;
   localparam int SHIFT    = 15;
   localparam int HALF     = TAPS / 2;
   localparam int HALF_P   = RATIO / 2;
   localparam int QN       = 512;
   localparam logic signed [15:0] C [TAPS] =
      '{-16'sd800, 16'sd0, 16'sd4800, 16'sd16384, 16'sd25000, 16'sd16384, 16'sd4800, -16'sd800};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_stb = 1'b0;
   logic signed [SAMPLE_W-1:0] in_data = '0;
   logic out_valid;
   logic out_phase;
   logic signed [OUT_W-1:0] out_data;

   always #2.5 clk = ~clk;

   interp2_fir #(.TAPS(TAPS), .DEPTH(DEPTH), .RATIO(RATIO), .SHIFT(SHIFT), .COEFS(C)) i_interp2_fir (
      .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_data(in_data),
      .out_valid(out_valid), .out_phase(out_phase), .out_data(out_data)
   );

   int total = 0;
   int bad = 0;
   longint cyc = 0;
   int hist [QN];
   int nh = 0;
   longint exp_cyc [QN];
   int exp_val [QN];
   int exp_ph [QN];
   string exp_tag [QN];
   int nexp = 0;
   int rd = 0;
   string cur_tag = "R1";
   logic signed [OUT_W-1:0] last_val = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what, input longint act, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // reference model of one branch from the requirements
   function automatic int model(input int ph);
      longint s = 0;
      for (int k = 0; k < HALF; k++) begin
         int idx = nh - 1 - 2 * k - ph;
         if (idx >= 0) s += longint'(C[2 * k + ph]) * longint'(hist[idx]);
      end
      s = (s + (longint'(1) <<< (SHIFT - 1))) >>> SHIFT;
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      return int'(s);
   endfunction

   // collector: every pulse compared against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (rd >= nexp) begin
               check(1'b0, "R7", "unexpected pulse at cycle", cyc, -1);
            end else begin
               check(cyc == exp_cyc[rd], "R7", {exp_tag[rd], " pulse cycle"}, cyc, exp_cyc[rd]);
               check(int'(out_phase) == exp_ph[rd], "R7", {exp_tag[rd], " branch"}, out_phase, exp_ph[rd]);
               check(int'(out_data) == exp_val[rd], exp_ph[rd] == 0 ? "R2" : "R3",
                     {exp_tag[rd], " value"}, out_data, exp_val[rd]);
               rd++;
            end
            last_val = out_data;
         end else begin
            check(out_data == last_val, "R8", "data moved without pulse", out_data, last_val);
         end
      end
   end

   // caller stands at a negedge; strobe accepted at the next edge
   task automatic do_sample(input int x, input int gap, input int junk_at);
      longint e0 = cyc + 1;
      in_stb  = 1'b1;
      in_data = SAMPLE_W'(x);
      hist[nh] = x;
      nh++;
      exp_cyc[nexp] = e0 + HALF_P; exp_val[nexp] = model(0); exp_ph[nexp] = 0; exp_tag[nexp] = cur_tag; nexp++;
      exp_cyc[nexp] = e0 + RATIO;  exp_val[nexp] = model(1); exp_ph[nexp] = 1; exp_tag[nexp] = cur_tag; nexp++;
      @(negedge clk);
      in_stb = 1'b0;
      for (int j = 1; j < gap; j++) begin
         if (j == junk_at) begin
            in_stb  = 1'b1;
            in_data = 16'sh5A5A;
         end else begin
            in_stb = 1'b0;
         end
         @(negedge clk);
      end
      in_stb = 1'b0;
   endtask

   task automatic t_reset();
      cur_tag = "R1";
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
      check(out_data == '0, "R1", "data in reset", out_data, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
      check(out_data == '0, "R1", "data after reset", out_data, 0);
   endtask

   task automatic t_impulse();
      cur_tag = "R1 R2 R3 impulse";
      do_sample(20000, RATIO + 3, 0);
      for (int i = 0; i < TAPS; i++) do_sample(0, RATIO + 3, 0);
   endtask

   task automatic t_back_to_back();
      cur_tag = "R7 R2 R3 back-to-back";
      for (int i = 0; i < 10; i++) do_sample(i * 3001 - 14000, RATIO, 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_wrap();
      cur_tag = "R4 wrap";
      for (int i = 0; i < 2 * DEPTH + 3; i++) do_sample(((i * 7919) % 60000) - 30000, RATIO + (i % 3), 0);
   endtask

   task automatic t_round();
      for (int i = 0; i < TAPS; i++) do_sample(0, RATIO, 0);
      cur_tag = "R5 round";
      do_sample(1, RATIO, 0);
      for (int i = 0; i < 3; i++) do_sample(0, RATIO, 0);
      do_sample(-1, RATIO, 0);
      for (int i = 0; i < 4; i++) do_sample(0, RATIO, 0);
   endtask

   task automatic t_sat();
      cur_tag = "R6 saturate";
      for (int i = 0; i < TAPS; i++) do_sample(32767, RATIO, 0);
      for (int i = 0; i < TAPS; i++) do_sample(-32768, RATIO, 0);
   endtask

   task automatic t_early();
      cur_tag = "R9 early strobe";
      do_sample(1234, RATIO + 2, 3);
      do_sample(-2222, RATIO + 1, RATIO - 1);
      do_sample(3333, RATIO, 1);
      for (int i = 0; i < HALF; i++) do_sample(0, RATIO + 1, 0);
   endtask

   initial begin
      #(200000 * 5.0);
      check(1'b0, "R7", "watchdog expired at cycle", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_impulse();
      t_back_to_back();
      t_wrap();
      t_round();
      t_sat();
      t_early();
      repeat (RATIO + 4) @(negedge clk);
      check(rd == nexp, "R7", "pulses received vs expected", rd, nexp);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule